// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block runs the digital side of a 16-bit successive-approximation conversion for a differential converter. The comparator and the two binary-weighted capacitor arrays sit outside it. The block shows each trial word on `trialDac` and reads the comparator's decision on `cmpIn`. A falling edge on the active-low `convStartN` ends acquisition and starts a conversion. `busy` rises at that point. The block then settles sixteen bits, most significant first. Each bit trial lasts a number of clock cycles set by `trialLen`.

When the last bit is settled, the finished word appears on `dataOut` on the same clock edge that drops `busy`. There is no pipeline, so the word always belongs to the conversion that just ended. The word is coded as two's complement or as offset binary, chosen by `codeSel`. After each conversion the sequencer returns to a low-power acquisition state, reported on `lowPower`. A serial readout port can keep `busy` high by holding `holdBusy`. The `powerDown` input halts all conversion activity, and `rst` aborts everything and clears the result.

All inputs are taken as synchronous to `clk`. An edge on `convStartN` is detected by comparing the input with its value at the previous clock edge.

Top module: `sar_sequencer`

## Requirements
- R1: A conversion starts at the first clock edge where `convStartN` is sampled low after being sampled high, with the block idle and `powerDown` low. `busy` is high from that edge.
- R2: The word is settled MSB first, one bit per trial. Each trial lasts N cycles, where N is `trialLen` latched at the start, and 0 counts as 1. During a trial, `trialDac` holds the bits already decided plus the trial bit set to 1. At the last cycle of the trial, `cmpIn`=1 keeps the bit and `cmpIn`=0 clears it.
- R3: `busy` falls, and `dataOut` takes the new word, at the edge exactly 16·N cycles after the start edge (no pipeline latency).
- R4: The raw word R is offset binary (0x0000 is most negative). With `codeSel`=0 (the default coding) `dataOut` is R XOR 0x8000, so positive full scale is 0x7FFF and negative full scale is 0x8000. With `codeSel`=1, `dataOut` is R.
- R5: After a conversion completes without extension, the block is in low-power acquisition: `lowPower`=1 and `busy`=0 until the next start.
- R6: If `holdBusy` is high at completion, `busy` stays high and `lowPower` stays low until the first edge that samples `holdBusy` low. The new word is still on `dataOut` at the completion edge.
- R7: `rst` (asynchronous, active high) aborts any conversion and clears `dataOut`, `trialDac` and `busy`.
- R8: `powerDown` high aborts a running conversion (`busy` low at the next edge, `dataOut` unchanged, `lowPower` low). Falling edges of `convStartN` while it is high start nothing.
- R9: A falling edge of `convStartN` while `busy` is high is ignored. The running conversion's timing and result are unchanged.
- R10: `dataOut` changes only at a completion edge or on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Asynchronous reset, active high |
| convStartN | input | 1 | Active-low convert start; a falling edge starts a conversion |
| powerDown | input | 1 | Halts conversion and ignores start requests |
| trialLen | input | 4 | Cycles per bit trial (0 means 1) |
| codeSel | input | 1 | 0: two's complement, 1: offset binary |
| holdBusy | input | 1 | Keeps busy high after completion while asserted |
| cmpIn | input | 1 | Comparator decision: 1 when the input is at or above the trial level |
| trialDac | output | 16 | Trial word for the capacitor arrays |
| busy | output | 1 | Conversion in progress (or extended) |
| lowPower | output | 1 | Low-power acquisition state |
| dataOut | output | 16 | Coded result of the last completed conversion |

## Verification
`busy` is due one edge after the start edge is sampled. The second trial word is due N edges after that. The result and the fall of `busy` are due exactly 16·N edges after the start edge, and the effects of a power-down or a `holdBusy` release one edge after they are sampled. The bench counts those edges explicitly from the start edge and reads the outputs on the falling clock edge. It also checks one edge before completion that `busy` is still high and the old word is still held. This pins the completion to a single cycle rather than a window. The comparator model answers from the trial word on the ports, so every expected code follows from the chosen analog value alone.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;    // begin a conversion: MSB trial
    logic decide;  // apply comparator to the current trial bit
    logic finish;  // register the coded result
    logic abort;   // drop the trial word
  } seqStrobe_t;

  typedef enum logic [1:0] {
    ST_ACQ  = 2'd0,
    ST_CONV = 2'd1,
    ST_HOLD = 2'd2,
    ST_OFF  = 2'd3
  } seqState_t;
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sarseq_pkg::*;
#(
  parameter int TLEN_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              convStartN,
  input  logic              powerDown,
  input  logic [TLEN_W-1:0] trialLen,
  input  logic              holdBusy,
  input  logic              lastBit,
  output seqStrobe_t        strobe,
  output logic              busy,
  output logic              lowPower
);
  seqState_t         state, stateNext;
  logic              prevStartN;
  logic              startFall;
  logic [TLEN_W-1:0] cnt, lenReg;
  logic              trialEnd;

  assign startFall = prevStartN & ~convStartN;
  assign trialEnd  = (cnt == lenReg - 1'b1);
  assign busy      = (state == ST_CONV) || (state == ST_HOLD);
  assign lowPower  = (state == ST_ACQ);

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (powerDown) begin
      stateNext = ST_OFF;
      if (state == ST_CONV) strobe.abort = 1'b1;
    end else begin
      unique case (state)
        ST_ACQ: if (startFall) begin
          strobe.load = 1'b1;
          stateNext   = ST_CONV;
        end
        ST_CONV: if (trialEnd) begin
          strobe.decide = 1'b1;
          if (lastBit) begin
            strobe.finish = 1'b1;
            stateNext     = holdBusy ? ST_HOLD : ST_ACQ;
          end
        end
        ST_HOLD: if (!holdBusy) stateNext = ST_ACQ;
        ST_OFF:  stateNext = ST_ACQ;
        default: stateNext = ST_ACQ;
      endcase
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state      <= ST_ACQ;
      prevStartN <= 1'b1;
      cnt        <= '0;
      lenReg     <= TLEN_W'(1);
    end else begin
      state      <= stateNext;
      prevStartN <= convStartN;
      if (strobe.load) begin
        cnt    <= '0;
        lenReg <= (trialLen == '0) ? TLEN_W'(1) : trialLen;
      end else if (state == ST_CONV) begin
        cnt <= trialEnd ? '0 : cnt + 1'b1;
      end
    end
  end

  // R1: an accepted start edge raises busy at once
  assert_busy_on_start_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACQ && startFall && !powerDown) |=> busy);

  // R8: power-down forces the off state with busy low
  assert_pd_halts_R8: assert property (@(posedge clk) disable iff (rst)
    powerDown |=> (!busy && state == ST_OFF));

  // R5: an unextended completion lands in low-power acquisition
  assert_lowpower_after_R5: assert property (@(posedge clk) disable iff (rst)
    (strobe.finish && !holdBusy && !powerDown) |=> (lowPower && !busy));

  // R9: a start edge during a running conversion leaves it running
  assert_ignore_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CONV && startFall && !powerDown && !strobe.finish) |=> (state == ST_CONV));

  // R6: an extended completion keeps busy asserted
  assert_hold_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (strobe.finish && holdBusy && !powerDown) |=> busy);
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sarseq_pkg::*;
#(
  parameter int RES = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  seqStrobe_t     strobe,
  input  logic           cmpIn,
  input  logic           codeSel,
  output logic           lastBit,
  output logic [RES-1:0] trialDac,
  output logic [RES-1:0] dataOut
);
  localparam logic [RES-1:0] SIGN = {1'b1, {(RES-1){1'b0}}};

  logic [RES-1:0] trialReg, maskReg, decided;

  assign decided  = cmpIn ? trialReg : (trialReg & ~maskReg);
  assign lastBit  = maskReg[0];
  assign trialDac = trialReg;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      trialReg <= '0;
      maskReg  <= '0;
      dataOut  <= '0;
    end else begin
      if (strobe.abort) begin
        trialReg <= '0;
        maskReg  <= '0;
      end else if (strobe.load) begin
        trialReg <= SIGN;
        maskReg  <= SIGN;
      end else if (strobe.decide) begin
        trialReg <= decided | (maskReg >> 1);
        maskReg  <= maskReg >> 1;
      end
      if (strobe.finish)
        dataOut <= codeSel ? decided : (decided ^ SIGN);
    end
  end

  // R2: each decision moves the single trial bit one place toward the LSB
  assert_msb_first_R2: assert property (@(posedge clk) disable iff (rst)
    (strobe.decide && !lastBit && !strobe.abort) |=>
      ($countones(maskReg) == 1 && maskReg == ($past(maskReg) >> 1)));

  // R10: the result word only moves on a completion
  assert_result_held_R10: assert property (@(posedge clk) disable iff (rst)
    !strobe.finish |=> $stable(dataOut));

  // R3: completion happens only on the LSB trial
  assert_finish_on_lsb_R3: assert property (@(posedge clk) disable iff (rst)
    strobe.finish |-> lastBit);
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
  parameter int RES    = 16,
  parameter int TLEN_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              convStartN,
  input  logic              powerDown,
  input  logic [TLEN_W-1:0] trialLen,
  input  logic              codeSel,
  input  logic              holdBusy,
  input  logic              cmpIn,
  output logic [RES-1:0]    trialDac,
  output logic              busy,
  output logic              lowPower,
  output logic [RES-1:0]    dataOut
);
  sarseq_pkg::seqStrobe_t strobe;
  logic lastBit;

  sar_ctrl #(.TLEN_W(TLEN_W)) u_ctrl (
    .clk(clk), .rst(rst), .convStartN(convStartN), .powerDown(powerDown),
    .trialLen(trialLen), .holdBusy(holdBusy), .lastBit(lastBit),
    .strobe(strobe), .busy(busy), .lowPower(lowPower)
  );

  sar_datapath #(.RES(RES)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .cmpIn(cmpIn), .codeSel(codeSel),
    .lastBit(lastBit), .trialDac(trialDac), .dataOut(dataOut)
  );
endmodule

// File: tb/tb_sar_sequencer.sv
`timescale 1ns/1ps
module tb_sar_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        convStartN = 1'b1;
  logic        powerDown = 1'b0;
  logic [3:0]  trialLen = 4'd0;
  logic        codeSel = 1'b0;
  logic        holdBusy = 1'b0;
  logic        cmpIn;
  logic [15:0] trialDac, dataOut;
  logic        busy, lowPower;
  logic [15:0] vinCode = 16'h0000;
  logic [15:0] lastOut = 16'h0000;
  int          nChecks = 0;
  int          nFails = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  // behavioural comparator: input at or above trial level keeps the bit
  assign cmpIn = (vinCode >= trialDac);

  sar_sequencer dut (
    .clk(clk), .rst(rst), .convStartN(convStartN), .powerDown(powerDown),
    .trialLen(trialLen), .codeSel(codeSel), .holdBusy(holdBusy), .cmpIn(cmpIn),
    .trialDac(trialDac), .busy(busy), .lowPower(lowPower), .dataOut(dataOut)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] coded(input logic [15:0] raw, input logic sel);
    return sel ? raw : (raw ^ 16'h8000);
  endfunction

  // full conversion with exact cycle accounting (R1 R2 R3 R4 R5 R10)
  task automatic runConv(input logic [15:0] vin, input logic [3:0] len, input logic sel);
    int n = (len == 0) ? 1 : int'(len);
    @(negedge clk);
    vinCode = vin; trialLen = len; codeSel = sel; convStartN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 busy after start", {15'd0, busy}, 16'd1);
    check("R2 msb trial word", trialDac, 16'h8000);
    repeat (n) @(posedge clk);
    @(negedge clk);
    check("R2 second trial word", trialDac, (vin & 16'h8000) | 16'h4000);
    repeat (15 * n - 1) @(posedge clk);
    @(negedge clk);
    check("R3 busy before end", {15'd0, busy}, 16'd1);
    check("R10 old word held", dataOut, lastOut);
    @(posedge clk);
    @(negedge clk);
    check("R3 busy falls on time", {15'd0, busy}, 16'd0);
    check("R4 coded result", dataOut, coded(vin, sel));
    check("R5 low power after", {15'd0, lowPower}, 16'd1);
    lastOut = coded(vin, sel);
    convStartN = 1'b1;
  endtask

  task automatic restartIgnored();
    @(negedge clk);
    vinCode = 16'h1234; trialLen = 4'd2; codeSel = 1'b1; convStartN = 1'b0;
    @(posedge clk);
    repeat (4) @(posedge clk);
    @(negedge clk) convStartN = 1'b1;
    @(posedge clk);
    @(negedge clk) convStartN = 1'b0;
    repeat (26) @(posedge clk);
    @(negedge clk);
    check("R9 still busy", {15'd0, busy}, 16'd1);
    @(posedge clk);
    @(negedge clk);
    check("R9 ends on original schedule", {15'd0, busy}, 16'd0);
    check("R9 result unaffected", dataOut, 16'h1234);
    lastOut = 16'h1234;
    convStartN = 1'b1;
  endtask

  task automatic holdExtends();
    @(negedge clk);
    vinCode = 16'hA5C3; trialLen = 4'd1; codeSel = 1'b0; holdBusy = 1'b1; convStartN = 1'b0;
    @(posedge clk);
    repeat (16) @(posedge clk);
    @(negedge clk);
    check("R6 busy extended", {15'd0, busy}, 16'd1);
    check("R6 word ready at completion", dataOut, 16'h25C3);
    check("R6 not low power", {15'd0, lowPower}, 16'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6 still extended", {15'd0, busy}, 16'd1);
    holdBusy = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R6 busy released", {15'd0, busy}, 16'd0);
    check("R5 low power after release", {15'd0, lowPower}, 16'd1);
    lastOut = 16'h25C3;
    convStartN = 1'b1;
  endtask

  task automatic powerDownTest();
    @(negedge clk);
    vinCode = 16'h0F0F; trialLen = 4'd2; codeSel = 1'b1; convStartN = 1'b0;
    @(posedge clk);
    repeat (6) @(posedge clk);
    @(negedge clk) powerDown = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R8 busy dropped", {15'd0, busy}, 16'd0);
    check("R8 word kept", dataOut, lastOut);
    check("R8 not low power", {15'd0, lowPower}, 16'd0);
    convStartN = 1'b1;
    @(negedge clk) convStartN = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R8 start ignored", {15'd0, busy}, 16'd0);
    convStartN = 1'b1;
    powerDown = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R8 idle after release", {15'd0, busy}, 16'd0);
    check("R8 word still kept", dataOut, lastOut);
  endtask

  task automatic resetAbort();
    @(negedge clk);
    vinCode = 16'hFFFF; trialLen = 4'd3; codeSel = 1'b0; convStartN = 1'b0;
    @(posedge clk);
    repeat (10) @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    #1;
    check("R7 busy cleared", {15'd0, busy}, 16'd0);
    check("R7 data cleared", dataOut, 16'h0000);
    check("R7 trial cleared", trialDac, 16'h0000);
    convStartN = 1'b1;
    @(negedge clk) rst = 1'b0;
    lastOut = 16'h0000;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R7 reset data", dataOut, 16'h0000);
    check("R7 reset busy", {15'd0, busy}, 16'd0);
    check("R5 reset idle low power", {15'd0, lowPower}, 16'd1);
    runConv(16'hFFFF, 4'd0, 1'b0);  // positive full scale two's complement
    runConv(16'h0000, 4'd3, 1'b0);  // negative full scale
    runConv(16'h8001, 4'd5, 1'b1);  // offset binary
    runConv(16'h3C5A, 4'd1, 1'b0);
    restartIgnored();
    holdExtends();
    powerDownTest();
    runConv(16'h7FFF, 4'd2, 1'b1);
    resetAbort();
    runConv(16'hC001, 4'd4, 1'b0);
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule